// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous request port and an external 16-bit asynchronous static RAM. A request carries an address, write data, a two-bit lane mask and a read/write flag. The controller latches the request and then runs the RAM strobes through a fixed sequence of phases. Each phase lasts a number of clocks that is derived from the clock period and the RAM's nanosecond timing limits. The user holds `req_valid` until `req_ready` pulses. For a read, the captured word is on `req_rdata` during that pulse.

Every strobe toward the RAM comes straight from a flip-flop. Address, lane enables and write data stay frozen from the first active strobe until chip enable rises again. The data driver toward the RAM is switched on only after the RAM has had time to release the bus after write enable falls. It is switched off on the same edge that raises write enable. Between requests chip enable is high, so the RAM sits in standby.

The state machine has six states:
- `ST_IDLE` accepts a request, which leads to `ST_RD_ACCESS` or `ST_WR_SETUP`.
- `ST_RD_ACCESS` lasts the access wait and then leads to `ST_RD_CAPTURE`, where the data is taken and ready pulses. The next state is `ST_IDLE`.
- `ST_WR_SETUP` lasts the bus release wait and then leads to `ST_WR_PULSE`, where data is driven.
- `ST_WR_PULSE` lasts the data setup time and then leads to `ST_WR_RECOVER`, where write enable rises and the driver turns off.
- `ST_WR_RECOVER` lasts the rest of the write cycle and then returns to `ST_IDLE` with ready pulsing.

Top module: `sram_byte_ctl`

## Requirements
- R1: After reset, and in every cycle with no request in progress, `sram_ce_n`, `sram_we_n`, `sram_oe_n` and both `sram_be_n` bits are 1 and `sram_dq_oe` is 0. `sram_we_n` low, `sram_oe_n` low or `sram_dq_oe` high only ever occur while `sram_ce_n` is low.
- R2: A write with mask 2'b11 stores all 16 bits. A later read with mask 2'b11 of the same address returns the full word.
- R3: Mask bit 0 drives `sram_be_n[0]` and selects data bits 7:0. Mask bit 1 drives `sram_be_n[1]` and selects bits 15:8. A write with mask 2'b01 or 2'b10 leaves the other lane of the stored word unchanged.
- R4: A read returns the selected lanes, and every unselected lane of `req_rdata` is zero. A write with mask 2'b00 changes no stored data, and a read with mask 2'b00 returns 16'h0000.
- R5: During a read, `sram_ce_n` and `sram_oe_n` are low, `sram_we_n` is high and `sram_dq_oe` is 0. Data is sampled no earlier than the access time after the strobes assert, which is 2 clocks at 200 MHz. `req_ready` is seen 3 clocks after the request is presented.
- R6: In a write, `sram_dq_oe` rises only after `sram_we_n` has been low for at least one clock. It falls on the edge where `sram_we_n` rises. Write data is driven and stable for at least 2 clocks before that edge. `req_ready` is seen 5 clocks after a write request is presented at 200 MHz.
- R7: `sram_oe_n` stays high while `sram_we_n` is low or `sram_dq_oe` is high, so the controller and the RAM never drive the data bus together.
- R8: `sram_addr`, `sram_be_n` and `sram_dq_o` hold constant while `sram_ce_n` stays low. `sram_addr` equals the requested address during the transaction.
- R9: `req_ready` is high for exactly one cycle per request. `req_rdata` keeps its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request pending, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Word address |
| req_wdata | input | DATA_W (16) | Write data |
| req_mask | input | LANES (2) | Lane select, bit 0 = bits 7:0 |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | DATA_W (16) | Last read result, unselected lanes zero |
| sram_addr | output | ADDR_W (16) | RAM address |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_be_n | output | LANES (2) | RAM lane enables, active low |
| sram_dq_o | output | DATA_W (16) | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Enable for the bus driver |
| sram_dq_i | input | DATA_W (16) | Data read from the bus |

## Verification
The hardest behaviour to expose at the ports is a controller that samples read data too early, or ends a write before its data has settled. Against an ideal memory both still look correct. The bench therefore attaches a lane-wise RAM model that returns a poison byte until the read strobes and address have been steady for the access time. The model commits a write lane only when write enable rises after at least two stable driven cycles. It also flags any overlap between its own output and the controller's driver, and any address movement during a write. Randomised full, half and empty masks over random addresses, combined with directed lane overlays on one word, drive these checks on every transaction.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } ctl_state_e;

    // clocks needed to cover a duration in ns
    function automatic int cyc_ceil(input int dur_ns, input int clk_ns);
        return (dur_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  mask_i,
    input  logic              write_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  mask_q,
    output logic              write_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            write_q <= 1'b0;
        end else if (capture) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            mask_q  <= mask_i;
            write_q <= write_i;
        end
    end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic [LANES-1:0]        mask,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] rdata_q
);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata_q[ln*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata_q[ln*LANE_W +: LANE_W] <= mask[ln] ? dq_i[ln*LANE_W +: LANE_W] : '0;
            end
        end

        AST_UNSEL_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (capture && !mask[ln]) |=> (rdata_q[ln*LANE_W +: LANE_W] == '0)); // R4
        AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !capture |=> $stable(rdata_q[ln*LANE_W +: LANE_W])); // R9
    end

endmodule

// File: rtl/sram_byte_ctl.sv
module sram_byte_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int LANE_W       = 8,
    parameter int LANES        = 2,
    parameter int CLK_NS       = 5,
    parameter int T_ACCESS_NS  = 10,
    parameter int T_RELEASE_NS = 5,
    parameter int T_SETUP_NS   = 6,
    parameter int T_PULSE_NS   = 8,
    parameter int T_CYCLE_NS   = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANES*LANE_W-1:0] req_wdata,
    input  logic [LANES-1:0]        req_mask,
    output logic                    req_ready,
    output logic [LANES*LANE_W-1:0] req_rdata,
    output logic [ADDR_W-1:0]       sram_addr,
    output logic                    sram_ce_n,
    output logic                    sram_we_n,
    output logic                    sram_oe_n,
    output logic [LANES-1:0]        sram_be_n,
    output logic [LANES*LANE_W-1:0] sram_dq_o,
    output logic                    sram_dq_oe,
    input  logic [LANES*LANE_W-1:0] sram_dq_i
);

    localparam int DATA_W  = LANES * LANE_W;
    localparam int RD_CYC  = imax(1, cyc_ceil(T_ACCESS_NS, CLK_NS));
    localparam int REL_CYC = imax(1, cyc_ceil(T_RELEASE_NS, CLK_NS));
    localparam int PUL_CYC = imax(imax(1, cyc_ceil(T_SETUP_NS, CLK_NS)),
                                  cyc_ceil(T_PULSE_NS, CLK_NS) - REL_CYC);
    localparam int REC_CYC = imax(1, cyc_ceil(T_CYCLE_NS, CLK_NS) - REL_CYC - PUL_CYC);
    localparam int MAX_CYC = imax(imax(RD_CYC, REL_CYC), imax(PUL_CYC, REC_CYC));
    localparam int CNT_W   = imax(1, $clog2(MAX_CYC + 1));

    ctl_state_e state_q, state_nxt;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              accept;
    logic              rd_take;

    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic [LANES-1:0]  lat_mask;
    logic              lat_write;

    logic              ce_n_q, we_n_q, oe_n_q, drv_q, ready_q;
    logic [LANES-1:0]  be_n_q, be_src;

    assign accept  = (state_q == ST_IDLE) && req_valid && !ready_q;
    assign rd_take = (state_q == ST_RD_ACCESS) && tmr_expired;
    assign be_src  = (state_q == ST_IDLE) ? ~req_mask : be_n_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .addr_i  (req_addr),
        .wdata_i (req_wdata),
        .mask_i  (req_mask),
        .write_i (req_write),
        .addr_q  (lat_addr),
        .wdata_q (lat_wdata),
        .mask_q  (lat_mask),
        .write_q (lat_write)
    );

    sram_rd_capture #(.LANE_W(LANE_W), .LANES(LANES)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_take),
        .mask    (lat_mask),
        .dq_i    (sram_dq_i),
        .rdata_q (req_rdata)
    );

    // next state and phase length
    always_comb begin
        state_nxt = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_nxt = ST_WR_SETUP;
                        tmr_val   = CNT_W'(REL_CYC - 1);
                    end else begin
                        state_nxt = ST_RD_ACCESS;
                        tmr_val   = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) state_nxt = ST_RD_CAPTURE;
            end
            ST_RD_CAPTURE: begin
                state_nxt = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (tmr_expired) begin
                    state_nxt = ST_WR_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(PUL_CYC - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_nxt = ST_WR_RECOVER;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(REC_CYC - 1);
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_expired) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // registered strobes, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n_q  <= 1'b1;
            we_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            be_n_q  <= '1;
            drv_q   <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= rd_take || ((state_q == ST_WR_RECOVER) && tmr_expired);
            unique case (state_nxt)
                ST_RD_ACCESS, ST_RD_CAPTURE: begin
                    ce_n_q <= 1'b0; we_n_q <= 1'b1; oe_n_q <= 1'b0;
                    be_n_q <= be_src; drv_q <= 1'b0;
                end
                ST_WR_SETUP: begin
                    ce_n_q <= 1'b0; we_n_q <= 1'b0; oe_n_q <= 1'b1;
                    be_n_q <= be_src; drv_q <= 1'b0;
                end
                ST_WR_PULSE: begin
                    ce_n_q <= 1'b0; we_n_q <= 1'b0; oe_n_q <= 1'b1;
                    be_n_q <= be_src; drv_q <= 1'b1;
                end
                ST_WR_RECOVER: begin
                    ce_n_q <= 1'b0; we_n_q <= 1'b1; oe_n_q <= 1'b1;
                    be_n_q <= be_src; drv_q <= 1'b0;
                end
                default: begin
                    ce_n_q <= 1'b1; we_n_q <= 1'b1; oe_n_q <= 1'b1;
                    be_n_q <= '1;   drv_q <= 1'b0;
                end
            endcase
        end
    end

    assign req_ready  = ready_q;
    assign sram_addr  = lat_addr;
    assign sram_dq_o  = lat_wdata;
    assign sram_ce_n  = ce_n_q;
    assign sram_we_n  = we_n_q;
    assign sram_oe_n  = oe_n_q;
    assign sram_be_n  = be_n_q;
    assign sram_dq_oe = drv_q;

    AST_STRB_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n || !sram_oe_n || sram_dq_oe) |-> !sram_ce_n); // R1
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n); // R5
    AST_DRV_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (!sram_we_n && $past(!sram_we_n))); // R6
    AST_DRV_OFF_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> !sram_dq_oe); // R6
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n); // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |->
            ($stable(sram_addr) && $stable(sram_be_n) && $stable(sram_dq_o))); // R8
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R9
    AST_WRITE_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(lat_write)); // R8

endmodule

// File: tb/sram_byte_ctl_tb.sv
module sram_byte_ctl_tb_top;

    localparam int RD_NEED = 2;   // access time in clocks at 200 MHz
    localparam int SU_NEED = 2;   // data setup in clocks
    localparam int DEPTH   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready;
    logic [15:0] req_rdata, sram_addr, sram_dq_o, sram_dq_i;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [1:0]  sram_be_n;

    int checks = 0;
    int errors = 0;
    int model_viol = 0;

    always #2.5 clk = ~clk;

    sram_byte_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .req_rdata(req_rdata), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_be_n(sram_be_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
        .sram_dq_i(sram_dq_i)
    );

    // ---------------- behavioural byte-lane RAM ----------------
    logic [15:0] mem [0:DEPTH-1];
    logic [15:0] ref_mem [0:DEPTH-1];
    int          rd_age;
    logic [15:0] rd_addr_prev;
    logic [1:0]  act_prev;
    int          su_cnt [2];
    logic [7:0]  su_data [2];
    logic [15:0] wr_addr [2];
    logic        rd_cond;

    assign rd_cond = !sram_ce_n && !sram_oe_n && sram_we_n;

    always_comb begin
        for (int l = 0; l < 2; l++) begin
            if (sram_dq_oe)
                sram_dq_i[l*8 +: 8] = sram_dq_o[l*8 +: 8];
            else if (rd_cond && !sram_be_n[l])
                sram_dq_i[l*8 +: 8] = (rd_age >= RD_NEED) ? mem[sram_addr[9:0]][l*8 +: 8] : 8'hA5;
            else
                sram_dq_i[l*8 +: 8] = 8'hEE;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            rd_age = 0;
            rd_addr_prev = '0;
            act_prev = '0;
            for (int l = 0; l < 2; l++) begin
                su_cnt[l] = 0; su_data[l] = '0; wr_addr[l] = '0;
            end
        end else begin
            if (rd_cond) rd_age = (rd_age > 0 && sram_addr == rd_addr_prev) ? rd_age + 1 : 1;
            else         rd_age = 0;
            rd_addr_prev = sram_addr;
            if (sram_dq_oe && rd_cond && sram_be_n != 2'b11) begin
                model_viol++;
                $display("FAIL R7: bus contention at %0t actual=1 expected=0", $time);
            end
            for (int l = 0; l < 2; l++) begin
                logic act;
                act = !sram_ce_n && !sram_we_n && !sram_be_n[l];
                if (act) begin
                    if (!act_prev[l]) wr_addr[l] = sram_addr;
                    else if (sram_addr != wr_addr[l]) begin
                        model_viol++;
                        $display("FAIL R8: address moved in write actual=%h expected=%h", sram_addr, wr_addr[l]);
                    end
                    if (sram_dq_oe) begin
                        su_cnt[l] = (su_cnt[l] > 0 && su_data[l] == sram_dq_o[l*8 +: 8]) ? su_cnt[l] + 1 : 1;
                        su_data[l] = sram_dq_o[l*8 +: 8];
                    end else begin
                        su_cnt[l] = 0;
                    end
                end else if (act_prev[l]) begin
                    if (su_cnt[l] >= SU_NEED) mem[wr_addr[l][9:0]][l*8 +: 8] = su_data[l];
                    else begin
                        model_viol++;
                        $display("FAIL R6: data setup clocks actual=%0d expected>=%0d", su_cnt[l], SU_NEED);
                    end
                    su_cnt[l] = 0;
                end
                act_prev[l] = act;
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [15:0] lane_merge(logic [15:0] old, logic [15:0] nw, logic [1:0] m);
        return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
    endfunction

    function automatic logic [15:0] lane_pick(logic [15:0] w, logic [1:0] m);
        return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_quiet(input string what);
        chk(sram_ce_n && sram_we_n && sram_oe_n && sram_be_n == 2'b11 && !sram_dq_oe,
            "R1", what, {27'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe},
            32'b111110);
    endtask

    // called at a negedge; returns at a negedge with the controller idle
    task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] m, input string tag, output logic [15:0] rd);
        int lat;
        req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 2) begin
                chk(sram_addr == a, "R8", "address on pins", {16'd0, sram_addr}, {16'd0, a});
                if (!wr)
                    chk(!sram_ce_n && !sram_oe_n && sram_we_n && !sram_dq_oe, "R5",
                        "read strobes", {28'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 32'b0010);
                else
                    chk(sram_be_n == ~m, "R3", "lane enables", {30'd0, sram_be_n}, {30'd0, ~m});
            end
        end while (!req_ready && lat < 40);
        rd = req_rdata;
        req_valid = 1'b0;
        if (wr) chk(lat == 5, "R6", "write ready latency", lat, 5);
        else    chk(lat == 3, "R5", "read ready latency", lat, 3);
        if (wr) ref_mem[a[9:0]] = lane_merge(ref_mem[a[9:0]], d, m);
        else    chk(rd == lane_pick(ref_mem[a[9:0]], m), tag, "read data",
                    {16'd0, rd}, {16'd0, lane_pick(ref_mem[a[9:0]], m)});
        @(negedge clk);
        chk(!req_ready, "R9", "ready width", {31'd0, req_ready}, 0);
        check_quiet("idle strobes after op");
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        logic [15:0] rd, held;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = '0; ref_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        check_quiet("reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("after reset release");

        // R2 full word at the top address
        run_op(1'b1, 16'hFFFF, 16'h1234, 2'b11, "R2", rd);
        run_op(1'b0, 16'hFFFF, 16'h0000, 2'b11, "R2", rd);
        // R3 lane overlays
        run_op(1'b1, 16'hFFFF, 16'h77AB, 2'b01, "R3", rd);
        run_op(1'b0, 16'hFFFF, 16'h0000, 2'b11, "R3", rd);
        chk(rd == 16'h12AB, "R3", "lower-lane overlay", {16'd0, rd}, 32'h12AB);
        run_op(1'b1, 16'hFFFF, 16'hCD99, 2'b10, "R3", rd);
        run_op(1'b0, 16'hFFFF, 16'h0000, 2'b11, "R3", rd);
        chk(rd == 16'hCDAB, "R3", "upper-lane overlay", {16'd0, rd}, 32'hCDAB);
        // R4 partial reads and empty mask
        run_op(1'b0, 16'hFFFF, 16'h0000, 2'b01, "R4", rd);
        run_op(1'b0, 16'hFFFF, 16'h0000, 2'b10, "R4", rd);
        run_op(1'b1, 16'hFFFF, 16'h5555, 2'b00, "R4", rd);
        run_op(1'b0, 16'hFFFF, 16'h0000, 2'b11, "R4", rd);
        chk(rd == 16'hCDAB, "R4", "empty-mask write", {16'd0, rd}, 32'hCDAB);
        run_op(1'b0, 16'hFFFF, 16'h0000, 2'b00, "R4", rd);
        chk(rd == 16'h0000, "R4", "empty-mask read", {16'd0, rd}, 0);
        // R9 read data held across a write
        run_op(1'b1, 16'h0000, 16'hBEEF, 2'b11, "R2", rd);
        run_op(1'b0, 16'h0000, 16'h0000, 2'b11, "R2", held);
        run_op(1'b1, 16'h0001, 16'h0F0F, 2'b11, "R2", rd);
        chk(req_rdata == held, "R9", "rdata held over write", {16'd0, req_rdata}, {16'd0, held});

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            logic [1:0]  m;
            a = 16'($urandom);
            if (n % 4 == 0) a = {a[15:4], 4'h3};   // revisit a few hot words
            m = 2'($urandom_range(0, 7) == 0 ? 0 : $urandom_range(1, 3));
            if ($urandom_range(0, 1) == 1)
                run_op(1'b1, a, 16'($urandom), m, "R3", rd);
            else
                run_op(1'b0, a, 16'h0000, m, (m == 2'b11) ? "R2" : "R4", rd);
        end

        chk(model_viol == 0, "R6", "RAM model timing violations (R7 R8)", model_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule